// File: doc/BRIEF.md
# Signed-Digit Digit-Product Generator

This block multiplies one high-radix signed digit by another. Each input digit has H ordinary bits, the posibits, with weights 1 through 2^(H-1). It also has one negabit at weight 1, which can add either 0 or -1. So a digit covers the range [-1, 2^H-1], and most values in that range have two encodings. The block is one cell of a multi-digit redundant-residue multiplier: a wider datapath instantiates many of these cells and arranges their outputs into partial products.

The product comes out as a two-digit high-radix signed-digit number. Each output digit has H posibits and one negabit, and that negabit sits at weight 2^H of its own digit. Internally, the block forms every bit product with one of three gate types and sums the bit products through a chain of full-adder ripple rows. It then re-encodes the sum into the two-digit form. The result is registered once, and the register has a synchronous active-low reset.

Top module: `sd_digit_mult`

## Requirements
- R1: An input negabit stored as 0 is worth -1, and stored as 1 it is worth 0. An input digit is worth sum(pos[i]*2^i) + (neg - 1).
- R2: An output digit is worth sum(pos[i]*2^i) + (neg - 1)*2^H. The product is worth hi*2^H + lo.
- R3: For every pair of input encodings, the product value equals the product of the two input digit values.
- R4: For H=3, the digit 3 times the digit 5 yields 15. This holds in both of the encodings available for each operand.
- R5: For H=3, the digit -1 times the digit 7 yields -7.
- R6: The digit -1 times the digit -1 yields +1.
- R7: If either operand is worth zero, in either of its two encodings, the output pattern is all posibits 0 and both negabits 1.
- R8: The output changes exactly one clock edge after the inputs change, and not before.
- R9: While rst_n is low at a clock edge, the output takes the zero pattern from R7, whatever the inputs are.
- R10: Out of reset, the upper output digit is never negative: hi_neg is always 1.
- R11: For H=3, the largest product, 7 times 7, yields 49.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_pos | input | H | Posibits of operand A |
| a_neg | input | 1 | Negabit of operand A, weight 1, stored 0 means -1 |
| b_pos | input | H | Posibits of operand B |
| b_neg | input | 1 | Negabit of operand B, weight 1, stored 0 means -1 |
| lo_pos | output | H | Posibits of the lower product digit |
| lo_neg | output | 1 | Negabit of the lower digit, weight 2^H |
| hi_pos | output | H | Posibits of the upper product digit |
| hi_neg | output | 1 | Negabit of the upper digit, weight 2^H |

## Verification
The bench sweeps every pair of input encodings for both H=3 and H=4.

- A wrong gate on any of the three bit-product types shows up as an off value. The bench also includes the pairs where both negabits are active, so a swapped NOR or AND gate gives a product with the wrong sign or a result off by one.
- A wrong bias constant shifts every result by a fixed amount.
- A faulty re-encoding either breaks the zero pattern or drives the upper negabit low.
- A missing or doubled output register is caught by sampling the output on both sides of the edge.

// File: rtl/sd_mult_pkg.sv
// Package: shared helpers for the signed-digit digit-product generator.
package sd_mult_pkg;

    // Offset added to the raw encoded bit sum so the re-encoder sees a
    // non-negative number: removes the 2*(2^h-1) negabit offset and adds
    // the 2^h + 4^h carried by the two output negabits.
    function automatic int sd_bias(input int h);
        return (1 << (2 * h)) - (1 << h) + 2;
    endfunction

endpackage

// File: rtl/sd_full_add.sv
// Module: one full-adder cell.
// Assumes: nothing; the polarity of the inputs is handled by the caller's bias.
module sd_full_add (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and majority carry.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end
endmodule

// File: rtl/sd_ripple_add.sv
// Module: W-bit ripple adder built from full-adder cells; the carry out of
// the top bit is dropped.
// Assumes: the caller sizes W so that the sum never wraps.
module sd_ripple_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W-1:0] c;

    assign c[0] = cin;

    // One cell per bit; the top bit only needs its sum.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < W - 1) begin : g_cell
            sd_full_add u_fa (
                .a  (a[i]),
                .b  (b[i]),
                .ci (c[i]),
                .s  (sum[i]),
                .co (c[i+1])
            );
        end else begin : g_top
            assign sum[i] = a[i] ^ b[i] ^ c[i];
        end
    end
endmodule

// File: rtl/sd_bitprod.sv
// Module: bit-product generator for two mixed-polarity digits.
// Assumes: negabits are stored inverted (0 means -1, 1 means 0).
//   posibit * posibit -> posibit : AND
//   posibit * negabit -> negabit : AND with the negabit input inverted,
//                                  output inverted
//   negabit * negabit -> posibit : NOR
module sd_bitprod #(
    parameter int H = 3
) (
    input  logic [H-1:0]        a_pos,
    input  logic                a_neg,
    input  logic [H-1:0]        b_pos,
    input  logic                b_neg,
    output logic [H-1:0][H-1:0] pp,      // pp[j][i] at weight 2^(i+j)
    output logic [H-1:0]        na_row,  // a_neg * b_pos[j], weight 2^j
    output logic [H-1:0]        nb_row,  // a_pos[i] * b_neg, weight 2^i
    output logic                nn_bit   // a_neg * b_neg, weight 1
);
    for (genvar j = 0; j < H; j++) begin : g_row
        for (genvar i = 0; i < H; i++) begin : g_col
            // Posibit by posibit.
            assign pp[j][i] = a_pos[i] & b_pos[j];
        end
        // Negabit of A by posibit of B.
        assign na_row[j] = ~(~a_neg & b_pos[j]);
        // Posibit of A by negabit of B.
        assign nb_row[j] = ~(a_pos[j] & ~b_neg);
    end

    // Negabit by negabit.
    assign nn_bit = ~(a_neg | b_neg);
endmodule

// File: rtl/sd_accum.sv
// Module: sums the encoded bit products through a chain of ripple rows.
// Assumes: each negabit is summed as its stored bit; the constant offset
// this causes is removed later by the bias in the re-encoder.
module sd_accum #(
    parameter int H  = 3,
    parameter int SW = 2 * H + 2
) (
    input  logic [H-1:0][H-1:0] pp,
    input  logic [H-1:0]        na_row,
    input  logic [H-1:0]        nb_row,
    input  logic                nn_bit,
    output logic [SW-1:0]       e_sum
);
    logic [SW-1:0] stage [0:H];

    // First row: row 0 of the posibit products plus the A-negabit row; the
    // negabit-by-negabit bit enters as the carry in.
    sd_ripple_add #(.W(SW)) u_row_first (
        .a   (SW'(pp[0])),
        .b   (SW'(na_row)),
        .cin (nn_bit),
        .sum (stage[0])
    );

    // Second row: the B-negabit row.
    sd_ripple_add #(.W(SW)) u_row_negb (
        .a   (stage[0]),
        .b   (SW'(nb_row)),
        .cin (1'b0),
        .sum (stage[1])
    );

    // Remaining posibit rows, each shifted to its weight.
    for (genvar j = 1; j < H; j++) begin : g_rows
        sd_ripple_add #(.W(SW)) u_row (
            .a   (stage[j]),
            .b   (SW'(pp[j]) << j),
            .cin (1'b0),
            .sum (stage[j+1])
        );
    end

    assign e_sum = stage[H];
endmodule

// File: rtl/sd_encode.sv
// Module: re-encodes the biased bit sum into two output digits. Each digit
// has H posibits and a negabit at weight 2^H.
// Assumes: e_sum + bias lies in [0, 2*4^H + 2^H - 1].
module sd_encode #(
    parameter int H  = 3,
    parameter int SW = 2 * H + 2
) (
    input  logic [SW-1:0] e_sum,
    output logic [H-1:0]  lo_pos,
    output logic          lo_neg,
    output logic [H-1:0]  hi_pos,
    output logic          hi_neg
);
    import sd_mult_pkg::*;

    localparam logic [SW-1:0] BIAS = SW'(sd_bias(H));
    localparam logic [H+1:0]  HALF = {2'b01, {H{1'b0}}};

    logic [SW-1:0] w;
    logic [H+1:0]  r;
    logic [H+1:0]  rr;

    // Split the biased sum into the lower posibits and a shared upper part,
    // then share the upper part between the two negabits and the upper
    // posibits.
    always_comb begin
        w      = e_sum + BIAS;
        lo_pos = w[H-1:0];
        r      = w[SW-1:H];
        hi_neg = r[H+1] | r[H];
        rr     = r - (hi_neg ? HALF : '0);
        lo_neg = |rr;
        hi_pos = rr[H-1:0] - {{(H-1){1'b0}}, lo_neg};
    end
endmodule

// File: rtl/sd_digit_mult.sv
// Module: top of the signed-digit digit-product generator. Combinational
// product logic followed by one output register.
// Assumes: synchronous active-low reset; the reset value is the encoding of
// zero (posibits 0, negabits 1).
module sd_digit_mult #(
    parameter int H = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [H-1:0] a_pos,
    input  logic         a_neg,
    input  logic [H-1:0] b_pos,
    input  logic         b_neg,
    output logic [H-1:0] lo_pos,
    output logic         lo_neg,
    output logic [H-1:0] hi_pos,
    output logic         hi_neg
);
    localparam int SW = 2 * H + 2;

    logic [H-1:0][H-1:0] pp;
    logic [H-1:0]        na_row;
    logic [H-1:0]        nb_row;
    logic                nn_bit;
    logic [SW-1:0]       e_sum;
    logic [H-1:0]        lo_pos_c;
    logic [H-1:0]        hi_pos_c;
    logic                lo_neg_c;
    logic                hi_neg_c;

    sd_bitprod #(.H(H)) u_bitprod (
        .a_pos  (a_pos),
        .a_neg  (a_neg),
        .b_pos  (b_pos),
        .b_neg  (b_neg),
        .pp     (pp),
        .na_row (na_row),
        .nb_row (nb_row),
        .nn_bit (nn_bit)
    );

    sd_accum #(.H(H), .SW(SW)) u_accum (
        .pp     (pp),
        .na_row (na_row),
        .nb_row (nb_row),
        .nn_bit (nn_bit),
        .e_sum  (e_sum)
    );

    sd_encode #(.H(H), .SW(SW)) u_encode (
        .e_sum  (e_sum),
        .lo_pos (lo_pos_c),
        .lo_neg (lo_neg_c),
        .hi_pos (hi_pos_c),
        .hi_neg (hi_neg_c)
    );

    // Output register: loads the product, or the zero encoding in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_pos <= '0;
            lo_neg <= 1'b1;
            hi_pos <= '0;
            hi_neg <= 1'b1;
        end else begin
            lo_pos <= lo_pos_c;
            lo_neg <= lo_neg_c;
            hi_pos <= hi_pos_c;
            hi_neg <= hi_neg_c;
        end
    end
endmodule

// File: rtl/sd_digit_mult_chk.sv
// Module: assertion checker for sd_digit_mult, attached with bind below.
// Assumes: the same H as the bound instance.
module sd_digit_mult_chk #(
    parameter int H = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [H-1:0] a_pos,
    input logic         a_neg,
    input logic [H-1:0] b_pos,
    input logic         b_neg,
    input logic [H-1:0] lo_pos,
    input logic         lo_neg,
    input logic [H-1:0] hi_pos,
    input logic         hi_neg
);
    int   prod_in;
    int   out_val;
    logic was_low = 1'b0;

    // Arithmetic value of the inputs' product and of the registered output.
    always_comb begin
        prod_in = (int'(a_pos) + int'(a_neg) - 1) * (int'(b_pos) + int'(b_neg) - 1);
        out_val = (int'(hi_pos) + (int'(hi_neg) - 1) * (1 << H)) * (1 << H)
                + int'(lo_pos) + (int'(lo_neg) - 1) * (1 << H);
    end

    // Tracks whether the previous edge saw reset asserted.
    always_ff @(posedge clk) begin
        was_low <= !rst_n;
        if (was_low) begin
            assert_reset_zero_R9: assert (lo_pos == '0 && lo_neg && hi_pos == '0 && hi_neg);
        end
    end

    assert_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_val == $past(prod_in));

    assert_hi_nonneg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hi_neg);

    assert_zero_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_in == 0) |=> (lo_pos == '0 && lo_neg && hi_pos == '0 && hi_neg));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(a_pos) && $stable(a_neg) && $stable(b_pos) && $stable(b_neg))
        |=> ($stable(lo_pos) && $stable(lo_neg) && $stable(hi_pos) && $stable(hi_neg)));
endmodule

bind sd_digit_mult sd_digit_mult_chk #(.H(H)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_pos  (a_pos),
    .a_neg  (a_neg),
    .b_pos  (b_pos),
    .b_neg  (b_neg),
    .lo_pos (lo_pos),
    .lo_neg (lo_neg),
    .hi_pos (hi_pos),
    .hi_neg (hi_neg)
);

// File: tb/sd_digit_mult_bench.sv
`timescale 1ns/1ps
module sd_digit_mult_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0] a3p, b3p, l3p, h3p;
    logic       a3n, b3n, l3n, h3n;
    logic [3:0] a4p, b4p, l4p, h4p;
    logic       a4n, b4n, l4n, h4n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    sd_digit_mult #(.H(3)) u_sd_digit_mult (
        .clk(clk), .rst_n(rst_n), .a_pos(a3p), .a_neg(a3n), .b_pos(b3p), .b_neg(b3n),
        .lo_pos(l3p), .lo_neg(l3n), .hi_pos(h3p), .hi_neg(h3n));

    sd_digit_mult #(.H(4)) u_sd_digit_mult_h4 (
        .clk(clk), .rst_n(rst_n), .a_pos(a4p), .a_neg(a4n), .b_pos(b4p), .b_neg(b4n),
        .lo_pos(l4p), .lo_neg(l4n), .hi_pos(h4p), .hi_neg(h4n));

    // R1: input digit value; the negabit stored as 0 is worth -1.
    function automatic int in_val(input int p, input logic n);
        return p + int'(n) - 1;
    endfunction

    // R2: output digit value; the negabit weighs 2^h.
    function automatic int out_dig(input int p, input logic n, input int h);
        return p + (int'(n) - 1) * (1 << h);
    endfunction

    function automatic int val3();
        return out_dig(int'(h3p), h3n, 3) * 8 + out_dig(int'(l3p), l3n, 3);
    endfunction

    function automatic int val4();
        return out_dig(int'(h4p), h4n, 4) * 16 + out_dig(int'(l4p), l4n, 4);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive one H=3 vector, then sample just after the next edge.
    task automatic apply3(input int ap, input logic an, input int bp, input logic bn, input string tag);
        @(negedge clk);
        a3p = 3'(ap); a3n = an; b3p = 3'(bp); b3n = bn;
        @(posedge clk);
        #1;
        check(tag, val3(), in_val(ap, an) * in_val(bp, bn));
        check("R10 h3 upper negabit", int'(h3n), 1);
    endtask

    task automatic apply4(input int ap, input logic an, input int bp, input logic bn, input string tag);
        @(negedge clk);
        a4p = 4'(ap); a4n = an; b4p = 4'(bp); b4n = bn;
        @(posedge clk);
        #1;
        check(tag, val4(), in_val(ap, an) * in_val(bp, bn));
        check("R10 h4 upper negabit", int'(h4n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: got no completion expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        a3p = 3'd3; a3n = 1'b1; b3p = 3'd5; b3n = 1'b1;
        a4p = 4'd9; a4n = 1'b1; b4p = 4'd7; b4n = 1'b1;

        // R9: reset forces the zero pattern despite non-zero operands.
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset h3", int'({h3p, h3n, l3p, l3n}), 17);
        check("R9 reset h4", int'({h4p, h4n, l4p, l4n}), 33);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: 3 x 5 in both encodings of each operand.
        apply3(3, 1'b1, 5, 1'b1, "R4 3x5");
        apply3(4, 1'b0, 6, 1'b0, "R4 3x5 alt encodings");
        check("R4 literal 15", val3(), 15);
        // R6: -1 x -1.
        apply3(0, 1'b0, 0, 1'b0, "R6 -1x-1");
        check("R6 literal 1", val3(), 1);
        // R5: -1 x 7.
        apply3(0, 1'b0, 7, 1'b1, "R5 -1x7");
        check("R5 literal -7", val3(), -7);
        // R11: largest product.
        apply3(7, 1'b1, 7, 1'b1, "R11 7x7");
        check("R11 literal 49", val3(), 49);
        // R7: zero operand in each encoding gives the zero pattern.
        apply3(1, 1'b0, 6, 1'b1, "R7 zero alt encoding");
        check("R7 pattern a", int'({h3p, h3n, l3p, l3n}), 17);
        apply3(5, 1'b0, 0, 1'b1, "R7 zero plain encoding");
        check("R7 pattern b", int'({h3p, h3n, l3p, l3n}), 17);

        // R8: the output holds the old product until the next edge.
        apply3(3, 1'b1, 3, 1'b1, "R8 setup");
        @(negedge clk);
        a3p = 3'd2; a3n = 1'b1; b3p = 3'd5; b3n = 1'b1;
        #1;
        check("R8 before edge", val3(), 9);
        @(posedge clk);
        #1;
        check("R8 after edge", val3(), 10);

        // R3: every pair of encodings, H=3 then H=4.
        for (int ap = 0; ap < 8; ap++)
            for (int an = 0; an < 2; an++)
                for (int bp = 0; bp < 8; bp++)
                    for (int bn = 0; bn < 2; bn++)
                        apply3(ap, 1'(an), bp, 1'(bn), "R3 h3 sweep");
        for (int ap = 0; ap < 16; ap++)
            for (int an = 0; an < 2; an++)
                for (int bp = 0; bp < 16; bp++)
                    for (int bn = 0; bn < 2; bn++)
                        apply4(ap, 1'(an), bp, 1'(bn), "R3 h4 sweep");

        // R9: reset taken mid-run clears the output again.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 mid-run reset", int'({h3p, h3n, l3p, l3n}), 17);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule